// File: doc/BRIEF.md
# Segment Translation and Page-Table Hash Unit

This block is the first stage of a segmented virtual-memory translator. It keeps a bank of sixteen 32-bit segment descriptors, selected by the top four bits of an effective address. For each access request it reads the chosen descriptor and works out four things: the protection key for the current privilege level, the no-execute and direct-store flags, the primary and secondary page-table hash values, and the compare tag that a later TLB or page-table walker matches against stored entries.

Accesses that land in a direct-store segment are settled here. Cache-maintenance operations and permitted integer accesses get an identity translation. Every other kind of access is rejected, and so is an integer access whose direction the key forbids. An instruction fetch from an ordinary segment marked no-execute gets a status of its own. Any other access to an ordinary segment is passed on with status "lookup" so the TLB can continue.

Requests arrive on a valid/ready stream and results leave on a registered valid/ready stream. A request is taken when `req_valid` and `req_ready` are both high. Its result appears on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the result is held unchanged and `req_ready` is low, so back-pressure passes straight through with no extra buffering. Descriptor writes use a plain write-enable port.

Top module: `seg_xlate_top`

## Requirements
- R1: Reset clears every segment descriptor to zero and drops `rsp_valid`. A request issued after reset sees a descriptor of zero.
- R2: When `seg_wr_en` is high, `seg_wr_data` is stored in the descriptor numbered `seg_wr_idx`. A request reads the descriptor numbered by `req_ea[31:28]`.
- R3: The descriptor fields are: bit 31 direct-store, bit 30 supervisor key, bit 29 user key, bit 28 no-execute, bits 23:0 segment id. `rsp_key` is 1 when bit 29 is set and `req_user` is 1, or when bit 30 is set and `req_user` is 0. Otherwise it is 0. `rsp_nx` and `rsp_ds` copy bits 28 and 31.
- R4: The page index is `req_ea[27:12]`. `rsp_hash_pri` is the 24-bit segment id XOR the zero-extended page index, and `rsp_hash_sec` is its bitwise complement.
- R5: `rsp_tag` (31 bits) is the segment id shifted left by 7, ORed with the page index shifted right by 10.
- R6: Status codes are: 0 lookup, 1 direct grant, 2 no-execute fault, 3 protection fault, 4 direct-store kind rejected. For an ordinary segment (bit 31 clear), a fetch (kind 5) with bit 28 set gives status 2. Every other access to an ordinary segment gives status 0, whatever bit 28 is. `rsp_raddr` is 0 whenever the status is not 1.
- R7: Access kinds are: 0 integer, 1 floating, 2 reservation, 3 cache operation, 4 external control, 5 fetch, 6 and 7 unused. In a direct-store segment, kind 3 gives status 1 with `rsp_raddr` equal to `req_ea`. Kinds 1, 2, 4, 5, 6 and 7 give status 4.
- R8: In a direct-store segment, an integer access gives status 3 when it is a load (`req_store`=0) with key 1, or a store with key 0. Otherwise it gives status 1 with `rsp_raddr` equal to `req_ea`.
- R9: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request's result is valid on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, every response output is held.
- R10: A request accepted in the same cycle as a write to its own descriptor uses the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_wr_en | input | 1 | Descriptor write strobe |
| seg_wr_idx | input | 4 | Descriptor number to write |
| seg_wr_data | input | 32 | Descriptor value to write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_ea | input | 32 | Effective address |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| req_store | input | 1 | 1 = store, 0 = load |
| req_kind | input | 3 | Access kind code |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_key | output | 1 | Selected protection key |
| rsp_nx | output | 1 | Segment no-execute flag |
| rsp_ds | output | 1 | Segment direct-store flag |
| rsp_hash_pri | output | 24 | Primary page-table hash |
| rsp_hash_sec | output | 24 | Secondary page-table hash |
| rsp_tag | output | 31 | Page-table entry compare tag |
| rsp_raddr | output | 32 | Identity real address on direct grant, else 0 |
| rsp_status | output | 3 | Outcome code |

## Verification
Directed passes set descriptors with only one key bit, then both key bits, then neither, and issue user and supervisor requests against each. This separates the two key terms and the privilege polarity. Direct-store descriptors are paired with every access kind, and with loads and stores under both key values, so that every branch of the kind and direction decision shows up in the status. A random phase writes descriptors with random ids and flags while requests and consumer stalls arrive at random. It covers hash and tag arithmetic over the full address range, same-cycle write/read collisions, and results held across long stalls. A reset in the middle of the run, after descriptors have been loaded, shows that they are cleared.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  // Descriptor word layout; positions are part of the block's behaviour.
  localparam int unsigned SEG_W      = 32;
  localparam int unsigned BIT_DSTORE = 31;
  localparam int unsigned BIT_KEY_SV = 30;
  localparam int unsigned BIT_KEY_US = 29;
  localparam int unsigned BIT_NOEXEC = 28;

  typedef enum logic [2:0] {
    ACC_INT    = 3'd0,
    ACC_FLOAT  = 3'd1,
    ACC_RESV   = 3'd2,
    ACC_CACHE  = 3'd3,
    ACC_EXTCTL = 3'd4,
    ACC_FETCH  = 3'd5
  } acc_kind_e;

  typedef enum logic [2:0] {
    XS_LOOKUP = 3'd0,
    XS_DIRECT = 3'd1,
    XS_NOEXEC = 3'd2,
    XS_PROT   = 3'd3,
    XS_DSREJ  = 3'd4
  } xl_status_e;

endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int unsigned NUM_SEG = 16,
  localparam int unsigned SEL_W  = $clog2(NUM_SEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [SEL_W-1:0] rd_idx,
  output logic [SEG_W-1:0] rd_data
);

  logic [SEG_W-1:0]   seg_q [NUM_SEG];
  logic [NUM_SEG-1:0] wr_hit;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_dec
    assign wr_hit[g] = wr_en && (wr_idx == SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SEG; i++) begin
      if (!rst_n)         seg_q[i] <= '0;
      else if (wr_hit[i]) seg_q[i] <= wr_data;
    end
  end

  // Read returns the value held before any write in the same cycle.
  assign rd_data = seg_q[rd_idx];

  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> seg_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/seg_hash_gen.sv
module seg_hash_gen
  import seg_xlate_pkg::*;
#(
  parameter int unsigned VSID_W    = 24,
  parameter int unsigned PGIDX_W   = 16,
  parameter int unsigned API_SHIFT = 10,
  parameter int unsigned TAG_SHIFT = 7,
  localparam int unsigned HASH_W   = (VSID_W > PGIDX_W) ? VSID_W : PGIDX_W,
  localparam int unsigned TAG_W    = VSID_W + TAG_SHIFT
) (
  input  logic [SEG_W-1:0]   seg_word,
  input  logic [PGIDX_W-1:0] page_idx,
  input  logic               user,
  output logic               key,
  output logic               noexec,
  output logic               dstore,
  output logic [HASH_W-1:0]  hash_pri,
  output logic [HASH_W-1:0]  hash_sec,
  output logic [TAG_W-1:0]   tag
);

  logic [VSID_W-1:0] vsid;
  logic              unused_rsvd;

  assign vsid        = seg_word[VSID_W-1:0];
  assign unused_rsvd = ^seg_word[BIT_NOEXEC-1:VSID_W];

  assign key    = (seg_word[BIT_KEY_US] & user) | (seg_word[BIT_KEY_SV] & ~user);
  assign noexec = seg_word[BIT_NOEXEC];
  assign dstore = seg_word[BIT_DSTORE];

  assign hash_pri = HASH_W'(vsid) ^ HASH_W'(page_idx);
  assign hash_sec = ~hash_pri;

  assign tag = (TAG_W'(vsid) << TAG_SHIFT) | TAG_W'(page_idx >> API_SHIFT);

endmodule

// File: rtl/seg_access_resolve.sv
module seg_access_resolve
  import seg_xlate_pkg::*;
#(
  parameter int unsigned EA_W = 32
) (
  input  logic            dstore,
  input  logic            noexec,
  input  logic            key,
  input  logic [2:0]      kind,
  input  logic            store,
  input  logic [EA_W-1:0] ea,
  output xl_status_e      status,
  output logic [EA_W-1:0] raddr
);

  always_comb begin
    status = XS_LOOKUP;
    if (!dstore) begin
      if (kind == ACC_FETCH && noexec) status = XS_NOEXEC;
    end else begin
      case (kind)
        ACC_CACHE: status = XS_DIRECT;
        ACC_INT: begin
          if ((!store && key) || (store && !key)) status = XS_PROT;
          else                                    status = XS_DIRECT;
        end
        default: status = XS_DSREJ;
      endcase
    end
  end

  assign raddr = (status == XS_DIRECT) ? ea : '0;

endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int unsigned NUM_SEG    = 16,
  parameter int unsigned EA_W       = 32,
  parameter int unsigned VSID_W     = 24,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned API_SHIFT  = 10,
  parameter int unsigned TAG_SHIFT  = 7,
  localparam int unsigned SEL_W     = $clog2(NUM_SEG),
  localparam int unsigned PGIDX_W   = EA_W - SEL_W - PAGE_SHIFT,
  localparam int unsigned HASH_W    = (VSID_W > PGIDX_W) ? VSID_W : PGIDX_W,
  localparam int unsigned TAG_W     = VSID_W + TAG_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seg_wr_en,
  input  logic [SEL_W-1:0]  seg_wr_idx,
  input  logic [SEG_W-1:0]  seg_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [EA_W-1:0]   req_ea,
  input  logic              req_user,
  input  logic              req_store,
  input  logic [2:0]        req_kind,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_key,
  output logic              rsp_nx,
  output logic              rsp_ds,
  output logic [HASH_W-1:0] rsp_hash_pri,
  output logic [HASH_W-1:0] rsp_hash_sec,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [EA_W-1:0]   rsp_raddr,
  output logic [2:0]        rsp_status
);

  logic [SEG_W-1:0]  seg_word;
  logic              c_key, c_nx, c_ds;
  logic [HASH_W-1:0] c_hpri, c_hsec;
  logic [TAG_W-1:0]  c_tag;
  xl_status_e        c_status;
  logic [EA_W-1:0]   c_raddr;
  logic              accept;

  seg_regfile #(.NUM_SEG(NUM_SEG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (seg_wr_en),
    .wr_idx  (seg_wr_idx),
    .wr_data (seg_wr_data),
    .rd_idx  (req_ea[EA_W-1 -: SEL_W]),
    .rd_data (seg_word)
  );

  seg_hash_gen #(
    .VSID_W    (VSID_W),
    .PGIDX_W   (PGIDX_W),
    .API_SHIFT (API_SHIFT),
    .TAG_SHIFT (TAG_SHIFT)
  ) u_hash (
    .seg_word (seg_word),
    .page_idx (req_ea[PAGE_SHIFT +: PGIDX_W]),
    .user     (req_user),
    .key      (c_key),
    .noexec   (c_nx),
    .dstore   (c_ds),
    .hash_pri (c_hpri),
    .hash_sec (c_hsec),
    .tag      (c_tag)
  );

  seg_access_resolve #(.EA_W(EA_W)) u_resolve (
    .dstore (c_ds),
    .noexec (c_nx),
    .key    (c_key),
    .kind   (req_kind),
    .store  (req_store),
    .ea     (req_ea),
    .status (c_status),
    .raddr  (c_raddr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_key      <= 1'b0;
      rsp_nx       <= 1'b0;
      rsp_ds       <= 1'b0;
      rsp_hash_pri <= '0;
      rsp_hash_sec <= '0;
      rsp_tag      <= '0;
      rsp_raddr    <= '0;
      rsp_status   <= '0;
    end else begin
      if (accept) begin
        rsp_valid    <= 1'b1;
        rsp_key      <= c_key;
        rsp_nx       <= c_nx;
        rsp_ds       <= c_ds;
        rsp_hash_pri <= c_hpri;
        rsp_hash_sec <= c_hsec;
        rsp_tag      <= c_tag;
        rsp_raddr    <= c_raddr;
        rsp_status   <= c_status;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R9
  take_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag) &&
      $stable(rsp_status) && $stable(rsp_raddr) && $stable(rsp_hash_pri)));

  // R7
  direct_needs_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == XS_DIRECT) |-> rsp_ds);

  // R6
  noexec_ordinary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == XS_NOEXEC) |-> (rsp_nx && !rsp_ds));

  // R8
  prot_needs_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == XS_PROT) |-> (rsp_ds && rsp_raddr == '0));

endmodule

// File: tb/tb_seg_xlate_top.sv
`timescale 1ns/1ps
module tb_seg_xlate_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        seg_wr_en;
  logic [3:0]  seg_wr_idx;
  logic [31:0] seg_wr_data;
  logic        req_valid, req_ready;
  logic [31:0] req_ea;
  logic        req_user, req_store;
  logic [2:0]  req_kind;
  logic        rsp_valid, rsp_ready;
  logic        rsp_key, rsp_nx, rsp_ds;
  logic [23:0] rsp_hash_pri, rsp_hash_sec;
  logic [30:0] rsp_tag;
  logic [31:0] rsp_raddr;
  logic [2:0]  rsp_status;

  always #2 clk = ~clk;

  seg_xlate_top dut (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_data(seg_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_user(req_user), .req_store(req_store), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_key(rsp_key), .rsp_nx(rsp_nx), .rsp_ds(rsp_ds),
    .rsp_hash_pri(rsp_hash_pri), .rsp_hash_sec(rsp_hash_sec),
    .rsp_tag(rsp_tag), .rsp_raddr(rsp_raddr), .rsp_status(rsp_status)
  );

  typedef struct {
    bit        key, nx, ds;
    bit [23:0] h1, h2;
    bit [30:0] tag;
    bit [31:0] raddr;
    bit [2:0]  st;
  } exp_t;

  int        checks = 0;
  int        errors = 0;
  int        cyc    = 0;
  string     phase  = "reset";
  bit [31:0] mseg [16];
  exp_t      q [$];

  // next-cycle stimulus
  bit        n_wr; bit [3:0] n_idx; bit [31:0] n_dat;
  bit        n_rv; bit [31:0] n_ea; bit n_user, n_store; bit [2:0] n_kind;
  bit        n_rr;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish act=%0d exp=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] %s act=%0h exp=%0h", req, phase, what, act, exp);
    end
  endtask

  function automatic exp_t predict(bit [31:0] ea, bit user, bit store, bit [2:0] kind);
    exp_t e;
    bit [31:0] sr  = mseg[ea >> 28];
    int        vs  = sr % (1 << 24);
    int        pg  = (ea >> 12) % (1 << 16);
    e.key = ((sr >> 29) % 2 == 1 && user) || ((sr >> 30) % 2 == 1 && !user);
    e.nx  = (sr >> 28) % 2;
    e.ds  = sr >> 31;
    e.h1  = 24'(vs ^ pg);
    e.h2  = 24'(~(vs ^ pg));
    e.tag = 31'((longint'(vs) * 128) + (pg / 1024));
    e.raddr = 0;
    if (!e.ds) e.st = (kind == 5 && e.nx) ? 3'd2 : 3'd0;
    else if (kind == 3) begin e.st = 1; e.raddr = ea; end
    else if (kind == 0) begin
      if (store != e.key) e.st = 3;
      else begin e.st = 1; e.raddr = ea; end
    end else e.st = 4;
    return e;
  endfunction

  function automatic string st_req(bit [2:0] st, bit ds);
    if (!ds) return "R6";
    if (st == 3 || st == 1) return "R8";
    return "R7";
  endfunction

  task automatic compare_out();
    if (q.size() == 0) begin
      chk(rsp_valid == 1'b0, "R9", "rsp_valid idle", rsp_valid, 0);
    end else begin
      exp_t e = q[0];
      chk(rsp_valid == 1'b1, "R9", "rsp_valid", rsp_valid, 1);
      chk(rsp_key == e.key, "R3", "key", rsp_key, e.key);
      chk(rsp_nx == e.nx && rsp_ds == e.ds, "R3", "nx/ds", {rsp_nx, rsp_ds}, {e.nx, e.ds});
      chk(rsp_hash_pri == e.h1, "R4", "hash_pri", rsp_hash_pri, e.h1);
      chk(rsp_hash_sec == e.h2, "R4", "hash_sec", rsp_hash_sec, e.h2);
      chk(rsp_tag == e.tag, "R5", "tag", rsp_tag, e.tag);
      chk(rsp_status == e.st, st_req(e.st, e.ds), "status", rsp_status, e.st);
      chk(rsp_raddr == e.raddr, st_req(e.st, e.ds), "raddr", rsp_raddr, e.raddr);
    end
  endtask

  task automatic tick();
    bit rdy;
    @(negedge clk);
    compare_out();
    seg_wr_en = n_wr; seg_wr_idx = n_idx; seg_wr_data = n_dat;
    req_valid = n_rv; req_ea = n_ea; req_user = n_user;
    req_store = n_store; req_kind = n_kind; rsp_ready = n_rr;
    #1;
    rdy = (q.size() == 0) || n_rr;
    chk(req_ready == rdy, "R9", "req_ready", req_ready, rdy);
    if (q.size() > 0 && n_rr) void'(q.pop_front());
    if (n_rv && rdy) q.push_back(predict(n_ea, n_user, n_store, n_kind));
    if (n_wr) mseg[n_idx] = n_dat;
    n_wr = 0; n_rv = 0; n_rr = 1;
  endtask

  task automatic wr(bit [3:0] idx, bit [31:0] d);
    n_wr = 1; n_idx = idx; n_dat = d; tick();
  endtask

  task automatic rq(bit [31:0] ea, bit user, bit store, bit [2:0] kind);
    n_rv = 1; n_ea = ea; n_user = user; n_store = store; n_kind = kind; tick();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; seg_wr_en = 0; req_valid = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    foreach (mseg[i]) mseg[i] = 0;
    q.delete();
  endtask

  initial begin
    n_wr = 0; n_rv = 0; n_rr = 1; n_idx = 0; n_dat = 0;
    n_ea = 0; n_user = 0; n_store = 0; n_kind = 0;
    seg_wr_idx = 0; seg_wr_data = 0; req_ea = 0;
    req_user = 0; req_store = 0; req_kind = 0;
    do_reset();
    phase = "R1 reset state";
    #1;
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1, "R1", "req_ready after reset", req_ready, 1);

    // R2: write and select by top address bits
    phase = "R2 write/select";
    wr(4'd5, 32'h00AB_CDEF);
    wr(4'd6, 32'h0012_3456);
    rq(32'h5123_4000, 0, 0, 0);
    rq(32'h6FFF_F000, 1, 1, 0);
    rq(32'h7000_0000, 0, 0, 0);
    tick();

    // R1: reset clears loaded descriptors
    phase = "R1 clear";
    do_reset();
    rq(32'h5123_4000, 1, 0, 0);
    tick();

    // R3: key polarity
    phase = "R3 key";
    wr(4'd1, 32'h2000_0001);
    wr(4'd2, 32'h4000_0002);
    wr(4'd3, 32'h6000_0003);
    for (int u = 0; u < 2; u++)
      for (int s = 1; s < 4; s++) rq({s[3:0], 28'h0ABC_000}, u[0], 0, 0);
    tick();

    // R6: no-execute only affects fetches in ordinary segments
    phase = "R6 noexec";
    wr(4'd4, 32'h1055_AA55);
    for (int k = 0; k < 8; k++) rq(32'h4876_5000, 0, 0, k[2:0]);
    tick();

    // R7: direct-store access kinds
    phase = "R7 ds kinds";
    wr(4'd8, 32'hB000_0777);
    for (int k = 0; k < 8; k++) rq(32'h8123_4567, 1, 0, k[2:0]);
    tick();

    // R8: direct-store integer direction vs key
    phase = "R8 ds int";
    wr(4'd9, 32'hC000_0000);
    wr(4'd10, 32'h8000_0000);
    for (int u = 0; u < 2; u++)
      for (int st = 0; st < 2; st++) begin
        rq(32'h9000_1234, u[0], st[0], 0);
        rq(32'hA000_4321, u[0], st[0], 0);
      end
    tick();

    // R10: same-cycle write and request to the same descriptor
    phase = "R10 collide";
    wr(4'd12, 32'h00F0_0F00);
    n_wr = 1; n_idx = 12; n_dat = 32'h9F0F_F0F0;
    rq(32'hC555_5000, 0, 0, 0);
    rq(32'hC555_5000, 0, 0, 0);
    tick();

    // R9: back-pressure and random traffic
    phase = "R9 random";
    for (int i = 0; i < 3000; i++) begin
      n_wr = ($urandom % 5) == 0;
      n_idx = 4'($urandom);
      n_dat = $urandom;
      n_rv = ($urandom % 4) != 0;
      n_ea = $urandom;
      n_user = 1'($urandom);
      n_store = 1'($urandom);
      n_kind = 3'($urandom);
      n_rr = ($urandom % 3) != 0;
      tick();
    end
    n_rr = 1;
    tick(); tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule